// File: doc/BRIEF.md
# Arithmetic Status and Control Flags Register

This block sits beside an integer ALU and turns each completed add, subtract or logical operation into a set of status flags. The ALU supplies both operands, the result, its carry or borrow out, an operation class and an operand size of 8, 16 or 32 bits. The block works out carry, overflow, sign, zero, auxiliary carry and parity for that size. It stores them in a 16-bit flags word with a fixed layout.

The same word also holds three control bits: block-transfer direction, interrupt enable and single-step trap. Separate set and clear command vectors drive these bits, and they act independently of the arithmetic strobe. The flags word comes straight from registers. A result strobed on one clock edge can be seen just after that edge.

Top module: `flag_unit`

## Requirements
- R1: Synchronous active-high reset loads the flags word to 0x0002. Bit positions: carry 0, parity 2, auxiliary carry 4, zero 6, sign 7, trap 8, interrupt 9, direction 10, overflow 11.
- R2: Bit 1 always reads 1. Bits 3, 5 and 15..12 always read 0.
- R3: For add (op_class 00) and subtract (op_class 01), the carry flag takes the value of carry_out: carry out of the top bit on add, borrow on subtract.
- R4: Overflow on add is set when both operands share a top bit and the result's top bit differs from it. On subtract (a minus b) it is set when the operands' top bits differ and the result's top bit differs from a's. Otherwise it is cleared.
- R5: Sign equals the top bit of the result at the selected size. op_size 00 selects 8 bits, 01 selects 16 bits, 10 selects 32 bits, and 11 is treated as 32 bits.
- R6: Zero is set exactly when the result bits within the selected size are all 0. Result bits above the size are ignored.
- R7: On add and subtract, auxiliary carry equals bit 4 of (a XOR b XOR result), which marks a carry out of bit 3 or a borrow into it.
- R8: Parity is 1 when result[7:0] holds an even number of 1s, for any size and any valid class.
- R9: A logical operation (op_class 10) clears carry, overflow and auxiliary carry, whatever carry_out is. Sign, zero and parity are still updated.
- R10: Status flags change only on an edge where op_valid is 1 and op_class is not 11. Otherwise they hold.
- R11: A ctl_set or ctl_clr bit (index 0 trap, 1 interrupt, 2 direction) takes effect on the next edge, whatever op_valid is. Clear wins over set. Bits with neither command hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation result strobe |
| op_class | input | 2 | 00 add, 01 subtract, 10 logical, 11 no status update |
| op_size | input | 2 | 00 byte, 01 word, 10/11 doubleword |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand (subtrahend on subtract) |
| result | input | DATA_W | ALU result |
| carry_out | input | 1 | Carry out of, or borrow into, the top bit at the selected size |
| ctl_set | input | 3 | Set commands for trap, interrupt, direction |
| ctl_clr | input | 3 | Clear commands for trap, interrupt, direction |
| flags | output | 16 | Registered flags word |

## Verification
The bench builds the block with DATA_W at its default of 32. This makes all three size lanes available, along with the reserved size code that falls back to the widest lane. The stimulus places results whose upper bits are non-zero under the byte size, which shows that zero and sign look only inside the selected width. It also applies the 0x7F+1 and 0x8000-1 boundaries, where overflow and auxiliary carry change. Control commands arrive together with arithmetic strobes, and set and clear also arrive in the same cycle.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_LOGIC = 2'b10,
    CLS_NONE  = 2'b11
  } op_cls_t;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } op_sz_t;

  localparam int FLAGS_W = 16;
  localparam int NCTL    = 3;

  localparam int FB_CF  = 0;
  localparam int FB_ONE = 1;
  localparam int FB_PF  = 2;
  localparam int FB_AF  = 4;
  localparam int FB_ZF  = 6;
  localparam int FB_SF  = 7;
  localparam int FB_TF  = 8;
  localparam int FB_IF  = 9;
  localparam int FB_DF  = 10;
  localparam int FB_OF  = 11;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } stat_t;

endpackage

// File: rtl/flagu_width_sel.sv
module flagu_width_sel
  import flagu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_sz_t              sz,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic [DATA_W-1:0]   r,
  output logic                a_msb,
  output logic                b_msb,
  output logic                r_msb,
  output logic                r_zero
);

  localparam int NLANE = $clog2(DATA_W / 8) + 1;
  localparam int SW    = (NLANE > 1) ? $clog2(NLANE) : 1;

  logic [NLANE-1:0] am;
  logic [NLANE-1:0] bm;
  logic [NLANE-1:0] rm;
  logic [NLANE-1:0] rz;
  logic [SW-1:0]    sel;

  for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
    localparam int LW = 8 << gi;
    assign am[gi] = a[LW-1];
    assign bm[gi] = b[LW-1];
    assign rm[gi] = r[LW-1];
    assign rz[gi] = ~|r[LW-1:0];
  end

  always_comb begin
    if (int'(sz) >= NLANE) sel = SW'(NLANE - 1);
    else                   sel = SW'(sz);
    a_msb  = am[sel];
    b_msb  = bm[sel];
    r_msb  = rm[sel];
    r_zero = rz[sel];
  end

endmodule

// File: rtl/flagu_status_calc.sv
module flagu_status_calc
  import flagu_pkg::*;
(
  input  op_cls_t    cls,
  input  logic       a_msb,
  input  logic       b_msb,
  input  logic       r_msb,
  input  logic       r_zero,
  input  logic       a4,
  input  logic       b4,
  input  logic       r4,
  input  logic [7:0] r_lo,
  input  logic       cy,
  output stat_t      nxt
);

  always_comb begin
    nxt    = '0;
    nxt.sf = r_msb;
    nxt.zf = r_zero;
    nxt.pf = ~^r_lo;
    unique case (cls)
      CLS_ADD: begin
        nxt.cf = cy;
        nxt.of = (a_msb == b_msb) && (r_msb != a_msb);
        nxt.af = a4 ^ b4 ^ r4;
      end
      CLS_SUB: begin
        nxt.cf = cy;
        nxt.of = (a_msb != b_msb) && (r_msb != a_msb);
        nxt.af = a4 ^ b4 ^ r4;
      end
      default: begin
        nxt.cf = 1'b0;
        nxt.of = 1'b0;
        nxt.af = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/flagu_ctl_reg.sv
module flagu_ctl_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_cmd,
  input  logic [N-1:0] clr_cmd,
  output logic [N-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_cmd) & ~clr_cmd;
  end

endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flagu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_class,
  input  logic [1:0]        op_size,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              carry_out,
  input  logic [2:0]        ctl_set,
  input  logic [2:0]        ctl_clr,
  output logic [15:0]       flags
);

  op_cls_t        cls;
  logic           a_msb, b_msb, r_msb, r_zero;
  stat_t          stat_nxt;
  stat_t          stat_q;
  logic [NCTL-1:0] ctl_q;
  logic           upd;

  assign cls = op_cls_t'(op_class);
  assign upd = op_valid && (cls != CLS_NONE);

  flagu_width_sel #(.DATA_W(DATA_W)) u_wsel (
    .sz     (op_sz_t'(op_size)),
    .a      (opnd_a),
    .b      (opnd_b),
    .r      (result),
    .a_msb  (a_msb),
    .b_msb  (b_msb),
    .r_msb  (r_msb),
    .r_zero (r_zero)
  );

  flagu_status_calc u_calc (
    .cls    (cls),
    .a_msb  (a_msb),
    .b_msb  (b_msb),
    .r_msb  (r_msb),
    .r_zero (r_zero),
    .a4     (opnd_a[4]),
    .b4     (opnd_b[4]),
    .r4     (result[4]),
    .r_lo   (result[7:0]),
    .cy     (carry_out),
    .nxt    (stat_nxt)
  );

  flagu_ctl_reg #(.N(NCTL)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .set_cmd (ctl_set),
    .clr_cmd (ctl_clr),
    .q       (ctl_q)
  );

  always_ff @(posedge clk) begin
    if (rst)      stat_q <= '0;
    else if (upd) stat_q <= stat_nxt;
  end

  always_comb begin
    flags         = '0;
    flags[FB_ONE] = 1'b1;
    flags[FB_CF]  = stat_q.cf;
    flags[FB_PF]  = stat_q.pf;
    flags[FB_AF]  = stat_q.af;
    flags[FB_ZF]  = stat_q.zf;
    flags[FB_SF]  = stat_q.sf;
    flags[FB_OF]  = stat_q.of;
    flags[FB_TF]  = ctl_q[0];
    flags[FB_IF]  = ctl_q[1];
    flags[FB_DF]  = ctl_q[2];
  end

endmodule

// File: rtl/flagu_checker.sv
module flagu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [1:0]        op_class,
  input logic [1:0]        op_size,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result,
  input logic              carry_out,
  input logic [2:0]        ctl_set,
  input logic [2:0]        ctl_clr,
  input logic [15:0]       flags
);

  localparam int CTL_POS [3] = '{8, 9, 10};

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (flags[1] == 1'b1) && (flags[3] == 1'b0) && (flags[5] == 1'b0) && (flags[15:12] == 4'h0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_class == 2'b11) |=>
      $stable({flags[11], flags[7], flags[6], flags[4], flags[2], flags[0]}));

  p_logic_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 2'b10) |=> (!flags[0] && !flags[11] && !flags[4]));

  p_carry_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_class[1]) |=> (flags[0] == $past(carry_out)));

  p_parity_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class != 2'b11) |=> (flags[2] == ~^$past(result[7:0])));

  for (genvar k = 0; k < 3; k++) begin : g_ctl
    p_ctl_clear_r11: assert property (@(posedge clk) disable iff (rst)
      ctl_clr[k] |=> !flags[CTL_POS[k]]);
    p_ctl_set_r11: assert property (@(posedge clk) disable iff (rst)
      (ctl_set[k] && !ctl_clr[k]) |=> flags[CTL_POS[k]]);
    p_ctl_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!ctl_set[k] && !ctl_clr[k]) |=> $stable(flags[CTL_POS[k]]));
  end

endmodule

bind flag_unit flagu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/flag_unit_test.sv
module flag_unit_test;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [1:0]    op_class = 2'b00;
  logic [1:0]    op_size = 2'b00;
  logic [DW-1:0] opnd_a = '0;
  logic [DW-1:0] opnd_b = '0;
  logic [DW-1:0] result = '0;
  logic          carry_out = 1'b0;
  logic [2:0]    ctl_set = '0;
  logic [2:0]    ctl_clr = '0;
  logic [15:0]   flags;

  always #4 clk = ~clk;

  flag_unit #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
    .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .carry_out(carry_out), .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags(flags)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  logic [5:0]  m_stat = '0;
  logic [2:0]  m_ctl = '0;

  function automatic logic [15:0] pack_word(logic [5:0] s, logic [2:0] c);
    logic [15:0] w;
    w = 16'h0002;
    w[0] = s[0]; w[2] = s[1]; w[4] = s[2];
    w[6] = s[3]; w[7] = s[4]; w[11] = s[5];
    w[8] = c[0]; w[9] = c[1]; w[10] = c[2];
    return w;
  endfunction

  // s = {of, sf, zf, af, pf, cf}
  function automatic logic [5:0] model_stat(logic [1:0] cls, logic [1:0] sz,
      logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] r, logic cy);
    int w;
    logic am, bm, rm, of, sf, zf, af, pf, cf;
    logic [DW-1:0] mask;
    w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    mask = (w == 32) ? '1 : ((DW'(1) << w) - 1);
    am = a[w-1]; bm = b[w-1]; rm = r[w-1];
    sf = rm;
    zf = ((r & mask) == '0);
    pf = ($countones(r[7:0]) % 2) == 0;
    cf = 1'b0; of = 1'b0; af = 1'b0;
    if (cls == 2'b00 || cls == 2'b01) begin
      cf = cy;
      af = a[4] ^ b[4] ^ r[4];
      if (cls == 2'b00) of = (am == bm) && (rm != am);
      else              of = (am != bm) && (rm != am);
    end
    return {of, sf, zf, af, pf, cf};
  endfunction

  task automatic do_op(logic v, logic [1:0] cls, logic [1:0] sz,
      logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] r, logic cy,
      logic [2:0] s, logic [2:0] c, string tag);
    item_t it;
    @(negedge clk);
    rst = 1'b0;
    op_valid = v; op_class = cls; op_size = sz;
    opnd_a = a; opnd_b = b; result = r; carry_out = cy;
    ctl_set = s; ctl_clr = c;
    if (v && cls != 2'b11) m_stat = model_stat(cls, sz, a, b, r, cy);
    m_ctl = (m_ctl | s) & ~c;
    it.exp = pack_word(m_stat, m_ctl);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic do_reset(string tag);
    item_t it;
    @(negedge clk);
    rst = 1'b1;
    op_valid = 1'b1; op_class = 2'b00; carry_out = 1'b1;
    ctl_set = 3'b111; ctl_clr = 3'b000;
    m_stat = '0; m_ctl = '0;
    it.exp = 16'h0002;
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      cur = q.pop_front();
      n_chk++;
      if (flags !== cur.exp) begin
        n_fail++;
        $display("FAIL %s: flags actual %h expected %h", cur.tag, flags, cur.exp);
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    do_reset("R1 reset value");
    // R4 R5 R7: 0x7F + 0x01 byte
    do_op(1, 2'b00, 2'b00, 32'h7F, 32'h01, 32'h80, 0, 0, 0, "R4 R5 R7 byte add overflow");
    // R3 R6 R8: 0xFF + 1 byte wraps to zero
    do_op(1, 2'b00, 2'b00, 32'hFF, 32'h01, 32'h00, 1, 0, 0, "R3 R6 R8 byte add carry zero");
    // R4: word 0x8000 - 1
    do_op(1, 2'b01, 2'b01, 32'h8000, 32'h1, 32'h7FFF, 0, 0, 0, "R4 word sub overflow");
    // R3: dword 0 - 1 borrow
    do_op(1, 2'b01, 2'b10, 32'h0, 32'h1, 32'hFFFF_FFFF, 1, 0, 0, "R3 dword sub borrow");
    // R9: logical clears carry even with carry_out high
    do_op(1, 2'b10, 2'b10, 32'h3, 32'h5, 32'h0000_0100, 1, 0, 0, "R9 logic clears cf of af");
    // R6: byte size ignores upper bits
    do_op(1, 2'b00, 2'b00, 32'h1200, 32'h0, 32'h1200, 0, 0, 0, "R6 byte zero ignores upper");
    do_op(1, 2'b00, 2'b10, 32'h1200, 32'h0, 32'h1200, 0, 0, 0, "R6 dword nonzero");
    // R10: strobe low, and class 11 strobed
    do_op(0, 2'b00, 2'b00, 32'h7F, 32'h1, 32'h80, 1, 0, 0, "R10 valid low holds");
    do_op(1, 2'b11, 2'b00, 32'h7F, 32'h1, 32'h80, 1, 0, 0, "R10 class 11 holds");
    // R5: reserved size behaves as 32 bits
    do_op(1, 2'b10, 2'b11, 32'h0, 32'h0, 32'h8000_0000, 0, 0, 0, "R5 size 11 as dword");
    do_op(1, 2'b10, 2'b01, 32'h0, 32'h0, 32'h8000_0000, 0, 0, 0, "R5 R6 word of dword msb");
    // R11: control bits
    do_op(0, 2'b00, 2'b00, 0, 0, 0, 0, 3'b111, 3'b000, "R11 set all control");
    do_op(0, 2'b00, 2'b00, 0, 0, 0, 0, 3'b001, 3'b001, "R11 clear wins trap");
    do_op(1, 2'b00, 2'b01, 32'h0FFF, 32'h0001, 32'h1000, 0, 3'b000, 3'b010,
          "R11 R7 clear intr with op");
    do_op(0, 2'b00, 2'b00, 0, 0, 0, 0, 3'b000, 3'b000, "R11 control hold");
    do_op(1, 2'b01, 2'b00, 32'h10, 32'h01, 32'h0F, 0, 3'b001, 3'b100, "R7 R11 sub af");
    // R8: odd parity byte with upper bits
    do_op(1, 2'b10, 2'b10, 0, 0, 32'hFFFF_FF07, 0, 0, 0, "R8 odd parity");
    do_reset("R1 reset mid run");
    do_op(0, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, "R1 R2 after reset idle");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule